// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block keeps the coherence state of every line of one private, direct-mapped cache that shares a bus with other masters. Each line is tagged Modified, Exclusive, Shared or Invalid. Processor reads and writes arrive with an address and wait for a completion pulse. When a processor access needs the bus, the block raises a bus request: a read, a read-for-ownership that invalidates other copies, or a write-back of a dirty victim. It completes the access when the bus grants that request.

The bus side watches the transactions of the other masters. A second, independent tag read port answers each snoop in the same cycle. It reports whether a valid copy is held and, when the copy is dirty, signals that this cache supplies the line in place of stale memory. Snoops downgrade or invalidate the local line at the clock edge. A processor access and a snoop that land on the same line slot in the same cycle are serialised: the snoop wins, and the processor access is looked up again one cycle later.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. No bus request and no completion are raised, and a snooped read of any address reports no copy held.
- R2: A processor read that misses raises bus_req_op = 1 (read) with the line address (offset bits zero). On the grant it fills the line as Exclusive if bus_shared is low and as Shared if it is high. req_done pulses in the cycle after the grant.
- R3: A processor write that misses raises bus_req_op = 2 (read-for-ownership) and fills the line as Modified on the grant.
- R4: A processor write to a Shared line raises bus_req_op = 2 before completing and leaves the line Modified.
- R5: A processor write to an Exclusive line completes with no bus request and leaves the line Modified.
- R6: Reads and writes that hit a Modified line, and reads that hit Shared or Exclusive, complete in the cycle after acceptance with no bus request.
- R7: A snooped read (snp_op = 1) that hits a Modified line raises snp_supply in that cycle, and the line becomes Shared.
- R8: A snooped read-for-ownership (snp_op = 2) or memory write (snp_op = 3) that hits a valid line makes it Invalid. A read-for-ownership that hits a Modified line also raises snp_supply.
- R9: A snooped read that hits any valid line raises snp_shared in the same cycle. A snoop that misses raises neither snp_shared nor snp_supply.
- R10: A miss whose slot holds a different Modified line first raises bus_req_op = 3 (write-back) with the victim's address, and issues the fill request only after that grant.
- R11: When a snoop and a processor request address the same line slot in the same cycle, the snoop's state change is applied first. The processor lookup is retried the next cycle against the updated state.
- R12: A snoop to a different line slot does not delay a processor access in the same cycle.
- R13: With two caches on one bus, a line never stays Modified or Exclusive in one cache while the other holds a valid copy. A write to a shared line goes to the bus, and a later miss by the other cache is served by intervention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present, held until req_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Processor byte address |
| req_done | output | 1 | One-cycle completion pulse |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_op | output | 2 | 1 read, 2 read-for-ownership, 3 write-back |
| bus_req_addr | output | ADDR_W | Line address of the request |
| bus_gnt | input | 1 | Bus grants the pending request this cycle |
| bus_shared | input | 1 | Another cache holds the line (sampled with a read grant) |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_op | input | 2 | 1 read, 2 read-for-ownership, 3 memory write |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_shared | output | 1 | A valid copy is held for a snooped read |
| snp_supply | output | 1 | This cache supplies the dirty line (intervention) |

## Verification
A snoop lookup and a processor lookup can fall in the same cycle, because the tag store has two read ports. The bench provokes this by driving a processor read to a line held Modified together with a snooped read of that same line. It expects intervention in that cycle, completion one cycle later than a plain hit, and a later read-for-ownership on a write, which shows the line was left Shared rather than overwritten. The same overlap aimed at a different slot must finish at plain-hit latency.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } line_st_e;

   // Bus request codes; snoop code 3 means a memory write by another master
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_RFO  = 2'd2,
      OP_WB   = 2'd3
   } bus_op_e;

endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
   import mesi_pkg::*;
#(
   parameter int LINES = 8,
   parameter int TAG_W = 9,
   parameter int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   // processor read port + write port
   input  logic [IDX_W-1:0] p_idx,
   output logic [TAG_W-1:0] p_tag,
   output line_st_e         p_state,
   input  logic             p_we,
   input  logic [TAG_W-1:0] p_wtag,
   input  line_st_e         p_wstate,
   // snoop read port + state write port
   input  logic [IDX_W-1:0] s_idx,
   output logic [TAG_W-1:0] s_tag,
   output line_st_e         s_state,
   input  logic             s_we,
   input  line_st_e         s_wstate
);

   logic [TAG_W-1:0] tag_q [LINES];
   line_st_e         st_q  [LINES];

   assign p_tag   = tag_q[p_idx];
   assign p_state = st_q[p_idx];
   assign s_tag   = tag_q[s_idx];
   assign s_state = st_q[s_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            tag_q[i] <= '0;
            st_q[i]  <= ST_I;
         end
      end else begin
         for (int i = 0; i < LINES; i++) begin
            if (s_we && s_idx == IDX_W'(i)) begin
               st_q[i] <= s_wstate;
            end else if (p_we && p_idx == IDX_W'(i)) begin
               tag_q[i] <= p_wtag;
               st_q[i]  <= p_wstate;
            end
         end
      end
   end

   // the interlock must keep the two writers off one slot
   assert_one_writer_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_we && p_we && s_idx == p_idx));

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
   import mesi_pkg::*;
#(
   parameter int TAG_W = 9
) (
   input  logic             snp_valid,
   input  logic [1:0]       snp_op,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic [TAG_W-1:0] line_tag,
   input  line_st_e         line_state,
   output logic             shared_o,
   output logic             supply_o,
   output logic             we_o,
   output line_st_e         wstate_o
);

   logic hit;

   always_comb begin
      hit      = snp_valid && (line_state != ST_I) && (line_tag == snp_tag);
      shared_o = hit && (snp_op == OP_RD);
      supply_o = hit && (line_state == ST_M) && (snp_op == OP_RD || snp_op == OP_RFO);
      we_o     = 1'b0;
      wstate_o = line_state;
      if (hit) begin
         case (snp_op)
            OP_RD: begin
               if (line_state != ST_S) begin
                  we_o     = 1'b1;
                  wstate_o = ST_S;
               end
            end
            OP_RFO, OP_WB: begin
               we_o     = 1'b1;
               wstate_o = ST_I;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/mesi_proc_ctrl.sv
module mesi_proc_ctrl
   import mesi_pkg::*;
#(
   parameter int TAG_W    = 9,
   parameter int IDX_W    = 3,
   parameter bit USE_EXCL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [TAG_W-1:0] req_tag,
   input  logic [IDX_W-1:0] req_idx,
   input  logic             clash,
   output logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   input  line_st_e         lk_state,
   output logic             wr_en,
   output logic [TAG_W-1:0] wr_tag,
   output line_st_e         wr_state,
   output logic             bus_req_valid,
   output bus_op_e          bus_op,
   output logic [TAG_W-1:0] bus_tag,
   output logic [IDX_W-1:0] bus_idx,
   input  logic             bus_gnt,
   input  logic             bus_shared,
   output logic             req_done
);

   typedef enum logic {PS_IDLE, PS_BUS} ps_e;

   ps_e              ps;
   bus_op_e          op_q, op_next_q;
   logic [TAG_W-1:0] cur_tag;
   logic [IDX_W-1:0] cur_idx;
   logic             done_q;
   logic             hit, accept, wb_live, granted;
   line_st_e         fill_st;

   generate
      if (USE_EXCL) begin : g_mesi_fill
         assign fill_st = bus_shared ? ST_S : ST_E;
      end else begin : g_msi_fill
         assign fill_st = ST_S;
      end
   endgenerate

   always_comb begin
      lk_idx        = (ps == PS_IDLE) ? req_idx : cur_idx;
      hit           = (lk_state != ST_I) && (lk_tag == req_tag);
      accept        = (ps == PS_IDLE) && req_valid && !clash && !done_q;
      wb_live       = (op_q == OP_WB) && (lk_state == ST_M);
      bus_req_valid = (ps == PS_BUS) && ((op_q != OP_WB) || wb_live);
      bus_op        = op_q;
      bus_tag       = (op_q == OP_WB) ? lk_tag : cur_tag;
      bus_idx       = cur_idx;
      granted       = bus_req_valid && bus_gnt;
      wr_en         = 1'b0;
      wr_tag        = cur_tag;
      wr_state      = ST_I;
      if (accept && hit && req_write && lk_state == ST_E) begin
         wr_en    = 1'b1;
         wr_tag   = req_tag;
         wr_state = ST_M;
      end else if (granted) begin
         wr_en = 1'b1;
         case (op_q)
            OP_WB:   begin wr_tag = lk_tag; wr_state = ST_I; end
            OP_RD:   wr_state = fill_st;
            default: wr_state = ST_M;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ps        <= PS_IDLE;
         op_q      <= OP_NONE;
         op_next_q <= OP_NONE;
         cur_tag   <= '0;
         cur_idx   <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            cur_tag <= req_tag;
            cur_idx <= req_idx;
            if (hit) begin
               if (req_write && lk_state == ST_S) begin
                  op_q <= OP_RFO;
                  ps   <= PS_BUS;
               end else begin
                  done_q <= 1'b1;
               end
            end else begin
               ps <= PS_BUS;
               if (lk_state == ST_M) begin
                  op_q      <= OP_WB;
                  op_next_q <= req_write ? OP_RFO : OP_RD;
               end else begin
                  op_q <= req_write ? OP_RFO : OP_RD;
               end
            end
         end else if (ps == PS_BUS) begin
            if (op_q == OP_WB && !wb_live) begin
               op_q <= op_next_q;        // victim lost its dirty data to a snoop
            end else if (granted) begin
               if (op_q == OP_WB) begin
                  op_q <= op_next_q;
               end else begin
                  op_q   <= OP_NONE;
                  ps     <= PS_IDLE;
                  done_q <= 1'b1;
               end
            end
         end
      end
   end

   assign req_done = done_q;

   assert_fill_completes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (granted && op_q != OP_WB) |=> req_done);

   assert_wb_before_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (granted && op_q == OP_WB) |=> (ps == PS_BUS && op_q != OP_WB));

   assert_single_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);

   assert_clash_defers_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ps == PS_IDLE && req_valid && clash && !done_q) |=> !req_done);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int OFF_W    = 4,
   parameter int LINES    = 8,
   parameter bit USE_EXCL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_done,
   output logic              bus_req_valid,
   output logic [1:0]        bus_req_op,
   output logic [ADDR_W-1:0] bus_req_addr,
   input  logic              bus_gnt,
   input  logic              bus_shared,
   input  logic              snp_valid,
   input  logic [1:0]        snp_op,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_supply
);

   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   generate
      if ((1 << IDX_W) != LINES) begin : g_bad_lines
         $error("LINES must be a power of two");
      end
      if (TAG_W < 1) begin : g_bad_split
         $error("ADDR_W too small for OFF_W and LINES");
      end
   endgenerate

   logic [TAG_W-1:0] req_tag, snp_tag, lk_tag, s_tag, wr_tag, bus_tag;
   logic [IDX_W-1:0] req_idx, snp_idx, lk_idx, bus_idx;
   line_st_e         lk_state, s_state, wr_state, s_wstate;
   logic             wr_en, s_we, clash;
   bus_op_e          bus_op;

   assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
   assign req_idx = req_addr[OFF_W +: IDX_W];
   assign snp_tag = snp_addr[ADDR_W-1 -: TAG_W];
   assign snp_idx = snp_addr[OFF_W +: IDX_W];
   assign clash   = snp_valid && (snp_idx == req_idx);

   mesi_tag_array #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .p_idx(lk_idx), .p_tag(lk_tag), .p_state(lk_state),
      .p_we(wr_en), .p_wtag(wr_tag), .p_wstate(wr_state),
      .s_idx(snp_idx), .s_tag(s_tag), .s_state(s_state),
      .s_we(s_we), .s_wstate(s_wstate)
   );

   mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
      .snp_valid(snp_valid), .snp_op(snp_op), .snp_tag(snp_tag),
      .line_tag(s_tag), .line_state(s_state),
      .shared_o(snp_shared), .supply_o(snp_supply),
      .we_o(s_we), .wstate_o(s_wstate)
   );

   mesi_proc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .USE_EXCL(USE_EXCL)) u_proc (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_tag(req_tag), .req_idx(req_idx), .clash(clash),
      .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_state(lk_state),
      .wr_en(wr_en), .wr_tag(wr_tag), .wr_state(wr_state),
      .bus_req_valid(bus_req_valid), .bus_op(bus_op),
      .bus_tag(bus_tag), .bus_idx(bus_idx),
      .bus_gnt(bus_gnt), .bus_shared(bus_shared),
      .req_done(req_done)
   );

   assign bus_req_op   = bus_op;
   assign bus_req_addr = {bus_tag, bus_idx, {OFF_W{1'b0}}};

   assert_req_has_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid |-> (bus_req_op != 2'd0));

   assert_supply_needs_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_supply && snp_op == 2'd1) |-> snp_shared);

   assert_snoop_read_keeps_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_op == 2'd1 && snp_shared && !req_valid) |=>
      (!snp_valid || snp_addr != $past(snp_addr) || snp_op != 2'd1 || snp_shared));

endmodule

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic        a_req = 0, a_wr = 0, b_req = 0, b_wr = 0;
   logic [15:0] a_addr = 0, b_addr = 0;
   logic        a_done, b_done, a_breq, b_breq, a_sh, b_sh, a_sup, b_sup;
   logic [1:0]  a_bop, b_bop;
   logic [15:0] a_baddr, b_baddr;
   logic        dma_valid = 0;
   logic [1:0]  dma_op = 0;
   logic [15:0] dma_addr = 0;

   // bus model: outside transaction first, then cache A, then cache B
   logic        a_gnt, b_gnt, a_snv, b_snv;
   logic [1:0]  a_snop, b_snop;
   logic [15:0] a_snaddr, b_snaddr;
   assign a_gnt    = a_breq && !dma_valid;
   assign b_gnt    = b_breq && !a_breq && !dma_valid;
   assign b_snv    = dma_valid || (a_gnt && a_bop != 2'd3);
   assign b_snop   = dma_valid ? dma_op : a_bop;
   assign b_snaddr = dma_valid ? dma_addr : a_baddr;
   assign a_snv    = dma_valid || (b_gnt && b_bop != 2'd3);
   assign a_snop   = dma_valid ? dma_op : b_bop;
   assign a_snaddr = dma_valid ? dma_addr : b_baddr;

   mesi_line_ctrl i_mesi_line_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(a_req), .req_write(a_wr), .req_addr(a_addr),
      .req_done(a_done), .bus_req_valid(a_breq), .bus_req_op(a_bop), .bus_req_addr(a_baddr),
      .bus_gnt(a_gnt), .bus_shared(b_sh), .snp_valid(a_snv), .snp_op(a_snop),
      .snp_addr(a_snaddr), .snp_shared(a_sh), .snp_supply(a_sup));

   mesi_line_ctrl i_mesi_line_ctrl_peer (
      .clk(clk), .rst_n(rst_n), .req_valid(b_req), .req_write(b_wr), .req_addr(b_addr),
      .req_done(b_done), .bus_req_valid(b_breq), .bus_req_op(b_bop), .bus_req_addr(b_baddr),
      .bus_gnt(b_gnt), .bus_shared(a_sh), .snp_valid(b_snv), .snp_op(b_snop),
      .snp_addr(b_snaddr), .snp_shared(b_sh), .snp_supply(b_sup));

   int checks = 0, errors = 0, cyc = 0;
   int a_ops = 0, b_ops = 0, a_sup_n = 0, b_sup_n = 0;
   logic [1:0]  a_last_op = 0, b_last_op = 0;
   logic [15:0] a_last_addr = 0, a_wb_addr = 0;

   always @(posedge clk) begin
      cyc++;
      if (a_gnt) begin a_ops++; a_last_op = a_bop; a_last_addr = a_baddr;
         if (a_bop == 2'd3) a_wb_addr = a_baddr; end
      if (b_gnt) begin b_ops++; b_last_op = b_bop; end
      if (a_sup) a_sup_n++;
      if (b_sup) b_sup_n++;
   end

   task automatic chk(string rq, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   function automatic logic [15:0] la(int tag, int idx);
      return 16'((tag << 7) | (idx << 4));
   endfunction

   // processor access on cache A (b=0) or B (b=1); returns negedges to completion
   task automatic access(bit b, bit wr, logic [15:0] ad, output int lat);
      @(negedge clk);
      if (b) begin b_req = 1; b_wr = wr; b_addr = ad; end
      else   begin a_req = 1; a_wr = wr; a_addr = ad; end
      lat = 0;
      do begin @(negedge clk); lat++; end while (!(b ? b_done : a_done) && lat < 50);
      a_req = 0; b_req = 0;
   endtask

   // outside transaction seen by both caches for one cycle
   task automatic probe(logic [1:0] op, logic [15:0] ad, output bit sh, output bit sup);
      @(negedge clk);
      dma_valid = 1; dma_op = op; dma_addr = ad;
      #1; sh = a_sh; sup = a_sup;
      @(negedge clk);
      dma_valid = 0; dma_op = 0;
   endtask

   task automatic t_reset;
      bit sh, sup;
      chk("R1 bus_req_valid", a_breq, 0);
      chk("R1 req_done", a_done, 0);
      probe(2'd1, la(1, 2), sh, sup);
      chk("R1 shared after reset", sh, 0);
      chk("R1 supply after reset", sup, 0);
   endtask

   task automatic t_read_exclusive;
      int lat, n; bit sh, sup;
      access(0, 0, la(1, 2), lat);
      chk("R2 read miss latency", lat, 2);
      chk("R2 op", a_last_op, 1);
      chk("R2 addr", a_last_addr, la(1, 2));
      n = a_ops;
      access(0, 1, la(1, 2), lat);
      chk("R5 silent write latency", lat, 1);
      chk("R5 no bus op", a_ops, n);
      probe(2'd1, la(1, 2), sh, sup);
      chk("R7 supply on dirty", sup, 1);
      chk("R9 shared on hit", sh, 1);
      probe(2'd1, la(1, 2), sh, sup);
      chk("R7 now shared, no supply", sup, 0);
      chk("R9 still shared", sh, 1);
      access(0, 1, la(1, 2), lat);
      chk("R4 upgrade latency", lat, 2);
      chk("R4 upgrade op", a_last_op, 2);
      n = a_ops;
      access(0, 0, la(1, 2), lat);
      chk("R6 read hit M latency", lat, 1);
      access(0, 1, la(1, 2), lat);
      chk("R6 write hit M latency", lat, 1);
      chk("R6 no bus op", a_ops, n);
   endtask

   task automatic t_invalidate;
      int lat; bit sh, sup;
      probe(2'd2, la(1, 2), sh, sup);
      chk("R8 rfo on M supplies", sup, 1);
      probe(2'd1, la(1, 2), sh, sup);
      chk("R8 invalid after rfo", sh, 0);
      access(0, 0, la(1, 2), lat);
      chk("R8 read misses again", lat, 2);
      probe(2'd3, la(1, 2), sh, sup);
      chk("R8 write on clean no supply", sup, 0);
      probe(2'd1, la(1, 2), sh, sup);
      chk("R8 invalid after write", sh, 0);
      probe(2'd1, la(5, 2), sh, sup);
      chk("R9 miss no shared", sh, 0);
   endtask

   task automatic t_two_caches;
      int lat, n;
      access(0, 0, la(3, 5), lat);           // A: Exclusive
      access(1, 0, la(3, 5), lat);           // B: must be Shared
      chk("R2 B read miss", lat, 2);
      access(1, 1, la(3, 5), lat);
      chk("R13 B write to shared goes to bus", lat, 2);
      chk("R13 B op rfo", b_last_op, 2);
      n = b_sup_n;
      access(0, 0, la(3, 5), lat);
      chk("R13 A copy was invalidated", lat, 2);
      chk("R13 B intervenes", b_sup_n - n, 1);
      access(0, 1, la(3, 5), lat);
      chk("R13 A write to shared goes to bus", a_last_op, 2);
      n = a_sup_n;
      access(1, 0, la(3, 5), lat);
      chk("R13 B miss after A write", lat, 2);
      chk("R13 A intervenes", a_sup_n - n, 1);
   endtask

   task automatic t_write_miss_victim;
      int lat;
      access(0, 1, la(7, 1), lat);
      chk("R3 write miss latency", lat, 2);
      chk("R3 op rfo", a_last_op, 2);
      access(0, 0, la(7, 1), lat);
      chk("R3 line modified hit", lat, 1);
      access(0, 0, la(9, 1), lat);
      chk("R10 victim latency", lat, 3);
      chk("R10 wb addr", a_wb_addr, la(7, 1));
      chk("R10 fill after wb", a_last_op, 1);
      chk("R10 fill addr", a_last_addr, la(9, 1));
   endtask

   task automatic t_collision;
      int lat; bit sup;
      access(0, 1, la(2, 6), lat);           // A: Modified
      @(negedge clk);
      a_req = 1; a_wr = 0; a_addr = la(2, 6);
      dma_valid = 1; dma_op = 2'd1; dma_addr = la(2, 6);
      #1; sup = a_sup;
      lat = 0;
      do begin @(negedge clk); lat++; dma_valid = 0; dma_op = 0; end
      while (!a_done && lat < 50);
      a_req = 0;
      chk("R11 snoop serviced (supply)", sup, 1);
      chk("R11 proc retried one cycle later", lat, 2);
      access(0, 1, la(2, 6), lat);
      chk("R11 line left shared", lat, 2);
      // now Modified: other-slot snoop in the same cycle must not delay
      @(negedge clk);
      a_req = 1; a_wr = 0; a_addr = la(2, 6);
      dma_valid = 1; dma_op = 2'd1; dma_addr = la(4, 3);
      lat = 0;
      do begin @(negedge clk); lat++; dma_valid = 0; dma_op = 0; end
      while (!a_done && lat < 50);
      a_req = 0;
      chk("R12 other slot no delay", lat, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_read_exclusive();
      t_invalidate();
      t_two_caches();
      t_write_miss_victim();
      t_collision();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(negedge clk) begin
      if (cyc > 20000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule